// File: doc/BRIEF.md
# Mode-Controlled GPIO Data Port

This block is one slice of a general-purpose I/O port that serves six pins. Every pin has a 2-bit mode. The mode gives the pin to an alternate peripheral, drives it as an output, or uses it as an input with or without a pull-up. A data register holds one bit per pin. Writes over a simple register bus always land in this register, whatever the mode. Only a pin in output mode carries the stored bit onto the pad.

Reads are chosen per pin. A pin in output or alternate-function mode returns its stored bit. A pin in either input mode returns its pad level, after that level has passed through a two-stage synchronizer. A 1-bit address selects between the data view and the mode register. A write strobe that is high for one cycle updates the selected register at the next clock edge. Read data follows the address combinationally.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, every data bit and every mode field is cleared to 00. After reset, both read views return zero, `pad_alt` is all ones, and `pad_oe`, `pad_pu` and `pad_out` are all zero.
- R2: Pin n takes its mode from mode register bits [2n+1:2n]. The codes are 00 alternate function, 01 output, 10 input with pull-up, and 11 input without pull-up. `pad_alt[n]` is high only for 00, `pad_oe[n]` only for 01, and `pad_pu[n]` only for 10.
- R3: In mode 01, `pad_out[n]` equals the stored data bit. In every other mode, `pad_out[n]` is 0.
- R4: A data-view read (`addr`=0) returns the stored bit in bit n for a pin in mode 00 or 01.
- R5: A data-view read returns the pad level for a pin in mode 10 or 11. A change on `pin_in` shows on the read after exactly two rising clock edges.
- R6: In the data view, bits 11 down to 6 always read 0. Write data in those bit positions is ignored.
- R7: A write to the data view (`addr`=0) updates the stored bits from `wdata[5:0]` in every mode. If the pin later enters output mode, the value written while it was in another mode drives the pad.
- R8: A write at `addr`=1 loads all 12 mode bits from `wdata`. A read at `addr`=1 returns them unchanged.
- R9: `rdata` follows `addr` within the same cycle, with no clock edge needed. A write takes effect at the rising edge on which `wr_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 1 | Register select: 0 data, 1 mode |
| wdata | input | 12 | Write data |
| rdata | output | 12 | Read data for the selected register |
| pin_in | input | 6 | Pad input levels (asynchronous) |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables |
| pad_pu | output | 6 | Pad pull-up enables |
| pad_alt | output | 6 | Alternate-function selects |

## Verification
Uniform mode patterns set all six pins to one mode, with data and pad levels chosen opposite to each other. This shows whether a read takes the stored bit or the pad level. Two mixed patterns place all four modes in one word and swap the data and pad values between them. These catch per-pin mux errors and field-position slips in the mode register. Directed sequences cover the two-edge synchronizer delay, writes to the reserved bits, and a write made in input mode that later appears when the pin becomes an output.

// File: rtl/gpio_port_pkg.sv
// Package gpio_port_pkg
// Shared mode codes and register-select values for the GPIO port slice.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        PM_ALT   = 2'b00,
        PM_OUT   = 2'b01,
        PM_IN_PU = 2'b10,
        PM_IN    = 2'b11
    } pin_mode_e;

    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_MODE = 1'b1;

endpackage

// File: rtl/gpio_sync.sv
// Module gpio_sync
// Two-flop synchronizer for asynchronous pad levels.
// Assumes: each bit is independent; multi-bit coherence is not needed.
module gpio_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    // Capture pad levels in two stages so metastability can settle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/gpio_regs.sv
// Module gpio_regs
// Holds the per-pin data bits and the 2-bit mode fields.
// Assumes: a one-cycle write strobe; data writes are accepted in every mode.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int PINS = 6,
    localparam int BUS_W = 2 * PINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [PINS-1:0]  data_q,
    output logic [BUS_W-1:0] mode_q
);

    // Update the register chosen by addr on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            if (addr == SEL_DATA) data_q <= wdata[PINS-1:0];
            else                  mode_q <= wdata;
        end
    end

    // R1: reset leaves every register cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (data_q == '0 && mode_q == '0));

    // R7: a data write lands regardless of mode
    assert_data_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_DATA) |=> data_q == $past(wdata[PINS-1:0]));

    // R8: a mode write loads the whole field set
    assert_mode_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_MODE) |=> mode_q == $past(wdata));

endmodule

// File: rtl/gpio_pin_ctrl.sv
// Module gpio_pin_ctrl
// Per-pin mode decode: pad controls and read-bit source.
// Assumes: pin_lvl is already synchronized.
module gpio_pin_ctrl
    import gpio_port_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       dat,
    input  logic       pin_lvl,
    output logic       out,
    output logic       oe,
    output logic       pu,
    output logic       alt,
    output logic       rd
);

    // Decode the mode into pad controls and pick the read source.
    always_comb begin
        oe  = 1'b0;
        pu  = 1'b0;
        alt = 1'b0;
        rd  = dat;
        unique case (pin_mode_e'(mode))
            PM_ALT:   alt = 1'b1;
            PM_OUT:   oe  = 1'b1;
            PM_IN_PU: begin pu = 1'b1; rd = pin_lvl; end
            PM_IN:    rd  = pin_lvl;
            default:  alt = 1'b1;
        endcase
        out = oe & dat;
    end

endmodule

// File: rtl/gpio_port.sv
// Module gpio_port
// Six-pin mode-controlled GPIO slice: registers, synchronizer, per-pin decode,
// and read mux.
// Assumes: addr selects data (0) or mode (1); reads are combinational.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int PINS = 6,
    localparam int BUS_W = 2 * PINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic [PINS-1:0]  pin_in,
    output logic [PINS-1:0]  pad_out,
    output logic [PINS-1:0]  pad_oe,
    output logic [PINS-1:0]  pad_pu,
    output logic [PINS-1:0]  pad_alt
);

    logic [PINS-1:0]  data_q;
    logic [BUS_W-1:0] mode_q;
    logic [PINS-1:0]  pin_sync;
    logic [PINS-1:0]  rd_bits;

    gpio_regs #(.PINS(PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .data_q(data_q), .mode_q(mode_q)
    );

    gpio_sync #(.W(PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        gpio_pin_ctrl u_ctrl (
            .mode(mode_q[2*n +: 2]), .dat(data_q[n]), .pin_lvl(pin_sync[n]),
            .out(pad_out[n]), .oe(pad_oe[n]), .pu(pad_pu[n]),
            .alt(pad_alt[n]), .rd(rd_bits[n])
        );
    end

    // Select the read view; unused data-view bits read as zero.
    always_comb begin
        if (addr == SEL_MODE) rdata = mode_q;
        else                  rdata = {{(BUS_W-PINS){1'b0}}, rd_bits};
    end

    // R2: at most one pad-control role per pin
    for (genvar n = 0; n < PINS; n++) begin : g_chk
        assert_one_role_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({pad_alt[n], pad_oe[n], pad_pu[n]}));
    end

    // R3: pad_out is low on any pin that is not driving
    assert_out_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R4: pins outside input modes read back the stored bit
    logic [PINS-1:0] in_mask;
    always_comb
        for (int n = 0; n < PINS; n++) in_mask[n] = mode_q[2*n+1];

    assert_stored_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == SEL_DATA) |-> ((rdata[PINS-1:0] ^ data_q) & ~in_mask) == '0);

    // R6: reserved bits of the data view are zero
    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == SEL_DATA) |-> rdata[BUS_W-1:PINS] == '0);

endmodule

// File: tb/gpio_port_tb.sv
// Bench for gpio_port: a vector table walked by one loop, then directed cases.
module gpio_port_tb;

    localparam int PINS  = 6;
    localparam int BUS_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             addr = 1'b0;
    logic [BUS_W-1:0] wdata = '0;
    logic [BUS_W-1:0] rdata;
    logic [PINS-1:0]  pin_in = '0;
    logic [PINS-1:0]  pad_out, pad_oe, pad_pu, pad_alt;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_alt(pad_alt)
    );

    typedef struct packed {
        logic [11:0] mode;
        logic [11:0] data;
        logic [5:0]  pin;
        logic [5:0]  rd;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{12'h555, 12'h0FF, 6'h00, 6'h3F},  // all output
        '{12'hFFF, 12'h02A, 6'h15, 6'h15},  // all input, no pull-up
        '{12'hAAA, 12'h000, 6'h3F, 6'h3F},  // all input with pull-up
        '{12'h000, 12'h015, 6'h2A, 6'h15},  // all alternate
        '{12'h9E4, 12'h0EB, 6'h14, 6'h07},  // mixed modes
        '{12'h9E4, 12'h014, 6'h2B, 6'h38}   // mixed, values swapped
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [11:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [11:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic logic [5:0] role(input logic [11:0] m, input logic [1:0] code);
        logic [5:0] r;
        for (int n = 0; n < 6; n++) r[n] = (m[2*n +: 2] == code);
        return r;
    endfunction

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(1'b0, v); check("R1 data view", v, 12'h000);
        rd(1'b1, v); check("R1 mode view", v, 12'h000);
        check("R1 alt", {6'b0, pad_alt}, 12'h03F);
        check("R1 oe/pu/out", {pad_oe, pad_pu}, 12'h000);
        check("R1 out", {6'b0, pad_out}, 12'h000);

        // table walk: R2 R3 R4 R5 R8
        for (int i = 0; i < 6; i++) begin
            wr(1'b1, VECS[i].mode);
            wr(1'b0, VECS[i].data);
            pin_in = VECS[i].pin;
            @(negedge clk); @(negedge clk);
            rd(1'b0, v); check("R4/R5 read mux", v, {6'b0, VECS[i].rd});
            rd(1'b1, v); check("R8 mode readback", v, VECS[i].mode);
            check("R2 alt", {6'b0, pad_alt}, {6'b0, role(VECS[i].mode, 2'b00)});
            check("R2 oe",  {6'b0, pad_oe},  {6'b0, role(VECS[i].mode, 2'b01)});
            check("R2 pu",  {6'b0, pad_pu},  {6'b0, role(VECS[i].mode, 2'b10)});
            check("R3 out", {6'b0, pad_out},
                  {6'b0, role(VECS[i].mode, 2'b01) & VECS[i].data[5:0]});
        end

        // R5: two-edge synchronizer latency
        wr(1'b1, 12'hFFF);
        pin_in = 6'h00;
        @(negedge clk); @(negedge clk);
        pin_in = 6'h3F;
        @(negedge clk);
        rd(1'b0, v); check("R5 after one edge", v, 12'h000);
        @(negedge clk);
        rd(1'b0, v); check("R5 after two edges", v, 12'h03F);

        // R7: write in input mode, then switch to output
        wr(1'b0, 12'h02D);
        pin_in = 6'h00;
        wr(1'b1, 12'h555);
        check("R7 out after switch", {6'b0, pad_out}, 12'h02D);
        rd(1'b0, v); check("R7 read stored", v, 12'h02D);

        // R6: reserved bits ignored on write, zero on read
        wr(1'b0, 12'hFC0);
        rd(1'b0, v); check("R6 reserved", v, 12'h000);

        // R9: combinational read and edge-timed write
        @(negedge clk);
        wr_en = 1'b1; addr = 1'b0; wdata = 12'h011;
        #1;
        check("R9 before edge", rdata, 12'h000);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R9 after edge", rdata, 12'h011);
        rd(1'b1, v); check("R9 mode view same cycle", v, 12'h555);

        // R1: reset mid-run clears state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(1'b1, v); check("R1 mode after reset", v, 12'h000);
        rd(1'b0, v); check("R1 data after reset", v, 12'h000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule